// File: doc/BRIEF.md
# Bit-Test Branch Resolver

This block sits in the branch stage of a 64-bit core. Each cycle it looks at one 32-bit instruction word, the program counter of that instruction and the 64-bit value already read from the instruction's source register. If the word is one of four test-bit branches, it reports whether the branch is taken and where it goes. Such a branch is taken or not on the state of a single bit of the source register, not on a comparison of two registers. The bit is picked by a 5-bit instruction field, and two of the four opcodes add 32 to that field so the bit lies in the upper half of the register.

The four major opcodes it claims are, in the default decoding, coprocessor loads and stores. An enable input selects between the two decodings. With the extension off, the four opcodes produce a coprocessor-unusable indication instead of a branch. Every other instruction is reported as not handled here, so the ordinary compare branches are left to the regular branch unit. Delay slots, flushing and register reads happen elsewhere. The block only passes out the register number to read.

All results are available combinationally. A single register stage with its own valid flag also holds them for the next pipeline stage.

Top module: `bbr_unit`

## Requirements
- R1: With the extension enabled, major opcode 0x32 (instr[31:26]) is a bit-test branch taken exactly when bit instr[20:16] of the source value is 0.
- R2: With the extension enabled, major opcode 0x36 is a bit-test branch taken exactly when bit (instr[20:16] + 32) of the source value is 0.
- R3: With the extension enabled, major opcode 0x3a is a bit-test branch taken exactly when bit instr[20:16] of the source value is 1.
- R4: With the extension enabled, major opcode 0x3e is a bit-test branch taken exactly when bit (instr[20:16] + 32) of the source value is 1.
- R5: For a bit-test branch, the target equals pc + 4 + (instr[15:0] sign-extended to 64 bits and shifted left by 2), taken from modulo 2^64, whether or not the branch is taken.
- R6: Any major opcode other than the four gives is_bitbr = 0, taken = 0, cop_fault = 0 and not_handled = 1, whatever the enable.
- R7: With the extension disabled, the four opcodes give cop_fault = 1, is_bitbr = 0, taken = 0 and not_handled = 0. With it enabled, cop_fault is never 1.
- R8: When in_valid is 1 at a rising clock edge, one cycle later q_valid = 1 and q_taken, q_target, q_bitbr and q_cop_fault hold the combinational results of that edge.
- R9: When in_valid is 0 at a rising edge, q_valid becomes 0 and the other registered outputs keep their values.
- R10: While rst_n is 0 at a rising edge, all registered outputs are cleared to 0.
- R11: src_sel always equals instr[25:21], the register whose value the caller must present on src_val.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_en | input | 1 | 1 = bit-test branch decoding, 0 = default decoding |
| in_valid | input | 1 | Instruction word is valid this cycle |
| instr | input | 32 | Instruction word |
| pc | input | 64 | Address of the instruction |
| src_val | input | 64 | Value of the register named by src_sel |
| src_sel | output | 5 | Source register number |
| is_bitbr | output | 1 | Word is a bit-test branch |
| taken | output | 1 | Bit-test branch is taken |
| target | output | 64 | Branch target address |
| cop_fault | output | 1 | Coprocessor-unusable indication |
| not_handled | output | 1 | Word is not for this block |
| q_valid | output | 1 | Registered stage holds a fresh result |
| q_bitbr | output | 1 | Registered is_bitbr |
| q_taken | output | 1 | Registered taken |
| q_target | output | 64 | Registered target |
| q_cop_fault | output | 1 | Registered cop_fault |

## Verification
The bench sweeps every bit index for all four opcodes. It uses a lone set bit, a lone clear bit and a pseudo-random word, so a design that forgets the +32 offset, inverts the polarity, or tests a neighbouring bit reports the wrong outcome at once. All 64 major opcodes are run with the enable both on and off. This catches a loose opcode match that claims a foreign instruction, and a missing coprocessor fault when the extension is off. Targets are checked with negative, maximum positive and wrap-around offsets, which exposes a zero-extended immediate or a missing +4. The register stage is checked for capture, for holding while idle, and for clearing on reset after it has held data.

// File: rtl/bbr_pkg.sv
// Shared constants and types for the bit-test branch resolver.
// Assumes a 6-bit major opcode in the top bits of the instruction word.
package bbr_pkg;

    localparam int OPC_W = 6;

    // Opcode bit 3 selects "branch if set", bit 2 selects the upper half.
    localparam logic [OPC_W-1:0] OPC_CLR_LO = 6'h32;
    localparam logic [OPC_W-1:0] OPC_CLR_HI = 6'h36;
    localparam logic [OPC_W-1:0] OPC_SET_LO = 6'h3a;
    localparam logic [OPC_W-1:0] OPC_SET_HI = 6'h3e;

    typedef struct packed {
        logic is_bb;     // recognised bit-test branch
        logic want_set;  // branch when the bit is 1
        logic upper;     // bit index offset by half the register width
    } bb_kind_t;

endpackage

// File: rtl/bbr_decode.sv
// Instruction decoder: classifies the word and slices out its fields.
// Assumes the instruction layout opcode[31:26], reg[25:21], bit[20:16], imm[15:0].
module bbr_decode
    import bbr_pkg::*;
#(
    parameter int ILEN = 32
) (
    input  logic [ILEN-1:0] instr,
    input  logic            ext_en,
    output bb_kind_t        kind,
    output logic            cop_fault,
    output logic            not_handled,
    output logic [4:0]      src_sel,
    output logic [4:0]      bit_field,
    output logic [15:0]     imm16
);

    localparam int OPC_LSB = ILEN - OPC_W;

    logic [OPC_W-1:0] opc;

    assign opc       = instr[ILEN-1:OPC_LSB];
    assign src_sel   = instr[25:21];
    assign bit_field = instr[20:16];
    assign imm16     = instr[15:0];

    // Map the major opcode to a branch kind or a coprocessor fault.
    always_comb begin
        kind      = '0;
        cop_fault = 1'b0;
        case (opc)
            OPC_CLR_LO, OPC_CLR_HI, OPC_SET_LO, OPC_SET_HI: begin
                if (ext_en) begin
                    kind.is_bb    = 1'b1;
                    kind.want_set = (opc == OPC_SET_LO) || (opc == OPC_SET_HI);
                    kind.upper    = (opc == OPC_CLR_HI) || (opc == OPC_SET_HI);
                end else begin
                    cop_fault = 1'b1;
                end
            end
            default: ;
        endcase
    end

    // Everything that is neither a branch here nor a fault goes elsewhere.
    assign not_handled = !kind.is_bb && !cop_fault;

endmodule

// File: rtl/bbr_bit_test.sv
// Single-bit condition: picks one register bit and compares it to the wanted polarity.
// Assumes XLEN is twice 32 so the 5-bit field plus the half offset covers every bit.
module bbr_bit_test #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] val,
    input  logic [4:0]      bit_field,
    input  logic            upper,
    input  logic            want_set,
    output logic            cond
);

    localparam int IDX_W = $clog2(XLEN);
    localparam int HALF  = XLEN / 2;

    logic [IDX_W-1:0] idx;
    logic [XLEN-1:0]  hit_vec;

    // Final bit index: field, plus half the width for the upper variants.
    always_comb begin
        idx = IDX_W'(bit_field) + (upper ? IDX_W'(HALF) : '0);
    end

    // One-hot select: each lane passes its bit only when it is the chosen one.
    for (genvar i = 0; i < XLEN; i++) begin : g_lane
        assign hit_vec[i] = (idx == IDX_W'(i)) && val[i];
    end

    assign cond = want_set ? (|hit_vec) : ~(|hit_vec);

endmodule

// File: rtl/bbr_target.sv
// Branch target adder: pc + 4 + word offset taken from a signed 16-bit immediate.
// Assumes byte addressing and 4-byte instructions; the sum wraps modulo 2^XLEN.
module bbr_target #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] pc,
    input  logic [15:0]     imm16,
    output logic [XLEN-1:0] target
);

    localparam int EXT_W = XLEN - 18;

    logic [XLEN-1:0] offs;

    // Sign-extend the immediate and scale it to bytes.
    always_comb begin
        offs   = {{EXT_W{imm16[15]}}, imm16, 2'b00};
        target = pc + XLEN'(4) + offs;
    end

endmodule

// File: rtl/bbr_unit.sv
// Bit-test branch resolver top: decode, bit condition, target, one output register stage.
// Assumes src_val already holds the register named by src_sel in the same cycle.
module bbr_unit
    import bbr_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int ILEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ext_en,
    input  logic            in_valid,
    input  logic [ILEN-1:0] instr,
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] src_val,
    output logic [4:0]      src_sel,
    output logic            is_bitbr,
    output logic            taken,
    output logic [XLEN-1:0] target,
    output logic            cop_fault,
    output logic            not_handled,
    output logic            q_valid,
    output logic            q_bitbr,
    output logic            q_taken,
    output logic [XLEN-1:0] q_target,
    output logic            q_cop_fault
);

    bb_kind_t    kind;
    logic [4:0]  bit_field;
    logic [15:0] imm16;
    logic        cond;

    bbr_decode #(.ILEN(ILEN)) u_dec (
        .instr       (instr),
        .ext_en      (ext_en),
        .kind        (kind),
        .cop_fault   (cop_fault),
        .not_handled (not_handled),
        .src_sel     (src_sel),
        .bit_field   (bit_field),
        .imm16       (imm16)
    );

    bbr_bit_test #(.XLEN(XLEN)) u_bit (
        .val       (src_val),
        .bit_field (bit_field),
        .upper     (kind.upper),
        .want_set  (kind.want_set),
        .cond      (cond)
    );

    bbr_target #(.XLEN(XLEN)) u_tgt (
        .pc     (pc),
        .imm16  (imm16),
        .target (target)
    );

    assign is_bitbr = kind.is_bb;
    assign taken    = kind.is_bb && cond;

    // Output stage: capture results on valid input, hold them otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_valid     <= 1'b0;
            q_bitbr     <= 1'b0;
            q_taken     <= 1'b0;
            q_target    <= '0;
            q_cop_fault <= 1'b0;
        end else begin
            q_valid <= in_valid;
            if (in_valid) begin
                q_bitbr     <= is_bitbr;
                q_taken     <= taken;
                q_target    <= target;
                q_cop_fault <= cop_fault;
            end
        end
    end

endmodule

// File: rtl/bbr_unit_chk.sv
// Property checker for bbr_unit, attached through bind; observes ports only.
module bbr_unit_chk #(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ext_en,
    input logic            in_valid,
    input logic            is_bitbr,
    input logic            taken,
    input logic [XLEN-1:0] target,
    input logic            cop_fault,
    input logic            not_handled,
    input logic            q_valid,
    input logic            q_bitbr,
    input logic            q_taken,
    input logic [XLEN-1:0] q_target,
    input logic            q_cop_fault
);

    // R6: a taken result only ever comes from a recognised bit-test branch.
    p_taken_branch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        taken |-> is_bitbr);

    // R6, R7: exactly one classification per word.
    p_one_class_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({is_bitbr, cop_fault, not_handled}) == 1);

    // R7: the fault only appears with the extension off.
    p_fault_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cop_fault |-> !ext_en);

    // R8: a valid input is captured into the register stage.
    p_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> q_valid && (q_taken == $past(taken)) && (q_target == $past(target))
                     && (q_bitbr == $past(is_bitbr)) && (q_cop_fault == $past(cop_fault)));

    // R9: an idle cycle drops valid and keeps the data.
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !q_valid && $stable(q_target) && $stable(q_taken));

    // R10: reset clears the register stage.
    p_reset_r10: assert property (@(posedge clk)
        !rst_n |=> !q_valid && !q_taken && (q_target == '0) && !q_bitbr && !q_cop_fault);

endmodule

bind bbr_unit bbr_unit_chk #(.XLEN(XLEN)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ext_en      (ext_en),
    .in_valid    (in_valid),
    .is_bitbr    (is_bitbr),
    .taken       (taken),
    .target      (target),
    .cop_fault   (cop_fault),
    .not_handled (not_handled),
    .q_valid     (q_valid),
    .q_bitbr     (q_bitbr),
    .q_taken     (q_taken),
    .q_target    (q_target),
    .q_cop_fault (q_cop_fault)
);

// File: tb/sim_bbr_unit.sv
// Self-checking bench for bbr_unit: sweeps opcodes, bit indices and offsets.
module sim_bbr_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ext_en;
    logic        in_valid;
    logic [31:0] instr;
    logic [63:0] pc;
    logic [63:0] src_val;
    logic [4:0]  src_sel;
    logic        is_bitbr, taken, cop_fault, not_handled;
    logic [63:0] target;
    logic        q_valid, q_bitbr, q_taken, q_cop_fault;
    logic [63:0] q_target;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    bbr_unit u0 (
        .clk(clk), .rst_n(rst_n), .ext_en(ext_en), .in_valid(in_valid),
        .instr(instr), .pc(pc), .src_val(src_val), .src_sel(src_sel),
        .is_bitbr(is_bitbr), .taken(taken), .target(target),
        .cop_fault(cop_fault), .not_handled(not_handled),
        .q_valid(q_valid), .q_bitbr(q_bitbr), .q_taken(q_taken),
        .q_target(q_target), .q_cop_fault(q_cop_fault)
    );

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one input set away from the rising edge, then let it settle.
    task automatic drive(bit ext, bit vld, logic [5:0] op, logic [4:0] rs,
                         logic [4:0] fld, logic [15:0] imm,
                         logic [63:0] p, logic [63:0] v);
        @(negedge clk);
        ext_en   = ext;
        in_valid = vld;
        instr    = {op, rs, fld, imm};
        pc       = p;
        src_val  = v;
        #1;
    endtask

    function automatic bit is_bb_op(logic [5:0] op);
        return (op == 6'h32) || (op == 6'h36) || (op == 6'h3a) || (op == 6'h3e);
    endfunction

    function automatic bit exp_taken(logic [5:0] op, logic [4:0] fld, logic [63:0] v);
        int idx;
        bit b;
        idx = int'(fld) + (((op == 6'h36) || (op == 6'h3e)) ? 32 : 0);
        b   = v[idx];
        return ((op == 6'h3a) || (op == 6'h3e)) ? b : !b;
    endfunction

    function automatic logic [63:0] exp_target(logic [63:0] p, logic [15:0] imm);
        logic [63:0] s;
        s = {{48{imm[15]}}, imm};
        return p + 64'd4 + (s << 2);
    endfunction

    function automatic string op_req(logic [5:0] op);
        case (op)
            6'h32:   return "R1";
            6'h36:   return "R2";
            6'h3a:   return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // Watchdog: a hung run is a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [5:0]  ops [4];
        logic [63:0] lfsr;
        logic [63:0] held_t;
        logic        held_k;
        ops[0] = 6'h32; ops[1] = 6'h36; ops[2] = 6'h3a; ops[3] = 6'h3e;
        lfsr = 64'hACE1_2468_9BDF_1357;

        rst_n = 1'b0; ext_en = 1'b1; in_valid = 1'b1;
        instr = '0; pc = '0; src_val = '0;
        repeat (3) @(posedge clk);
        #1;
        // R10: reset state.
        chk("R10 q_valid", q_valid, 0);
        chk("R10 q_taken", q_taken, 0);
        chk("R10 q_target", q_target, 0);
        chk("R10 q_cop_fault", q_cop_fault, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1-R4 sweep with R5, R8 and R11 on every vector.
        for (int oi = 0; oi < 4; oi++) begin
            for (int f = 0; f < 32; f++) begin
                for (int pat = 0; pat < 3; pat++) begin
                    logic [63:0] v, p;
                    logic [15:0] imm;
                    logic [4:0]  rs;
                    int idx;
                    string rq;
                    idx = f + (((ops[oi] == 6'h36) || (ops[oi] == 6'h3e)) ? 32 : 0);
                    lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
                    case (pat)
                        0:       v = 64'h1 << idx;
                        1:       v = ~(64'h1 << idx);
                        default: v = lfsr;
                    endcase
                    imm = 16'(f * 1031 + oi * 97 + pat * 40961);
                    p   = {lfsr[63:2], 2'b00};
                    rs  = 5'(f + pat + oi);
                    rq  = op_req(ops[oi]);
                    drive(1'b1, 1'b1, ops[oi], rs, 5'(f), imm, p, v);
                    chk({rq, " taken"}, taken, exp_taken(ops[oi], 5'(f), v));
                    chk({rq, " is_bitbr"}, is_bitbr, 1);
                    chk("R7 no fault when enabled", cop_fault, 0);
                    chk("R6 not_handled low", not_handled, 0);
                    chk("R5 target", target, exp_target(p, imm));
                    chk("R11 src_sel", src_sel, rs);
                    @(posedge clk);
                    #1;
                    chk("R8 q_valid", q_valid, 1);
                    chk("R8 q_taken", q_taken, exp_taken(ops[oi], 5'(f), v));
                    chk("R8 q_target", q_target, exp_target(p, imm));
                    chk("R8 q_bitbr", q_bitbr, 1);
                end
            end
        end

        // R6 / R7: every major opcode with the extension on and off.
        for (int e = 0; e < 2; e++) begin
            for (int op = 0; op < 64; op++) begin
                drive(e[0], 1'b1, 6'(op), 5'd3, 5'd7, 16'h0010, 64'h1000, 64'h0);
                if (is_bb_op(6'(op))) begin
                    if (e == 0) begin
                        chk("R7 cop_fault", cop_fault, 1);
                        chk("R7 is_bitbr", is_bitbr, 0);
                        chk("R7 taken", taken, 0);
                        chk("R7 not_handled", not_handled, 0);
                        @(posedge clk);
                        #1;
                        chk("R7 q_cop_fault", q_cop_fault, 1);
                    end
                end else begin
                    chk("R6 not_handled", not_handled, 1);
                    chk("R6 is_bitbr", is_bitbr, 0);
                    chk("R6 taken", taken, 0);
                    chk("R6 cop_fault", cop_fault, 0);
                end
            end
        end

        // R5 corners: most negative, most positive, wrap past zero and past the top.
        drive(1'b1, 1'b1, 6'h3a, 5'd1, 5'd0, 16'h8000, 64'h0000_0000_0000_0100, 64'h1);
        chk("R5 negative wrap", target, 64'hFFFF_FFFF_FFFE_0104);
        drive(1'b1, 1'b1, 6'h3a, 5'd1, 5'd0, 16'h7FFF, 64'h0000_0000_0001_0000, 64'h1);
        chk("R5 max positive", target, 64'h0000_0000_0003_0000);
        drive(1'b1, 1'b1, 6'h32, 5'd1, 5'd0, 16'hFFFF, 64'h0000_0000_0000_2000, 64'h1);
        chk("R5 minus one word", target, 64'h0000_0000_0000_2000);
        chk("R1 not taken when bit set", taken, 0);
        drive(1'b1, 1'b1, 6'h3e, 5'd1, 5'd31, 16'h0001, 64'hFFFF_FFFF_FFFF_FFFC, 64'h8000_0000_0000_0000);
        chk("R5 top wrap", target, 64'h0000_0000_0000_0004);
        chk("R4 top bit", taken, 1);

        // R9: an idle cycle keeps the held result and drops valid.
        drive(1'b1, 1'b1, 6'h36, 5'd2, 5'd5, 16'h0123, 64'h4000, 64'h0);
        @(posedge clk);
        #1;
        held_t = q_target;
        held_k = q_taken;
        chk("R8 load before hold", held_k, 1);
        drive(1'b1, 1'b0, 6'h3a, 5'd2, 5'd5, 16'h0777, 64'h9000, 64'h0);
        @(posedge clk);
        #1;
        chk("R9 q_valid low", q_valid, 0);
        chk("R9 q_target held", q_target, held_t);
        chk("R9 q_taken held", q_taken, held_k);

        // R10: reset clears a loaded register stage.
        drive(1'b1, 1'b1, 6'h36, 5'd2, 5'd5, 16'h0123, 64'h4000, 64'h0);
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        chk("R10 q_valid after reset", q_valid, 0);
        chk("R10 q_target after reset", q_target, 0);
        chk("R10 q_taken after reset", q_taken, 0);
        chk("R10 q_bitbr after reset", q_bitbr, 0);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        summary();
        $finish;
    end

endmodule